// File: doc/BRIEF.md
# Dual-Bank Memory Access Scheduler

This block decides, for a pair of back-to-back instructions, in which clock cycle each data-memory access is carried out. There are two single-ported data banks. An access is either a read belonging to the instruction about to issue or a write belonging to the instruction now finishing. Each instruction can carry up to three accesses: one from its main operation, one through the first address generator and one through the second. Every access names the bank it targets.

The six possible accesses are numbered in a fixed priority order. Each access goes into the earliest cycle in which its bank is still free, so a lower-priority access to a busy bank moves to a later cycle. Reads of the next instruction rank ahead of writes of the current one. As a result, a write followed by a read of the same bank costs an extra cycle.

A `start` strobe in the idle state captures the access set and registers the stall count and the read span. A two-state sequencer then plays the schedule one cycle per clock, showing the slot that owns each bank in that cycle.

- States: `SQ_IDLE` (waiting for work) and `SQ_PLAY` (stepping through the schedule).
- Transitions:
  - **capture**: `SQ_IDLE` to `SQ_PLAY` when `start` is high and at least one access is valid.
  - **empty**: stay in `SQ_IDLE` when `start` is high but no access is valid. The stall count and read span are still registered.
  - **step**: `SQ_PLAY` to `SQ_PLAY` on every cycle except the last.
  - **finish**: `SQ_PLAY` to `SQ_IDLE` after the last scheduled cycle.

Top module: `dbs_sched`

## Requirements
- R1: The slot numbers are fixed. Slots 0, 1 and 2 are the next instruction's main, first-generator and second-generator reads. Slots 3, 4 and 5 are the current instruction's main, first-generator and second-generator writes. Bit i of `acc_vld` and bit i of `acc_bank` belong to slot i, and a lower slot number means higher priority.
- R2: In any cycle each bank is granted to at most one slot, and the two banks may be granted to two different slots in the same cycle.
- R3: A valid slot is played in the cycle whose index equals the number of valid lower-numbered slots that target the same bank (bank A is `acc_bank` bit 0, bank B is bit 1). Cycle indices start at 0.
- R4: A slot whose valid bit is 0 is never granted and takes no cycle. Outside `SQ_PLAY` both grant valids are 0.
- R5: On any one bank, every read grant is played before every write grant.
- R6: The schedule length n is the larger of the two per-bank valid counts. `stall_cnt` is registered on capture as n-1, or 0 when n is 0.
- R7: `rd_span` is registered on capture as one more than the largest cycle index among the valid read slots, or 0 when no read slot is valid.
- R8: After the capture edge, `busy` is high for exactly n cycles, and `cyc_idx` shows 0 to n-1 in turn. `last_cyc` is high only in cycle n-1, and the block then returns to `SQ_IDLE`. When n is 0 the block stays idle.
- R9: While `busy` is high, `start`, `acc_vld` and `acc_bank` are ignored. The grants, `stall_cnt` and `rd_span` follow the captured set only.
- R10: During reset `busy`, both grant valids, `last_cyc`, `stall_cnt` and `rd_span` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Capture strobe, honoured in the idle state only |
| acc_vld | input | 6 | Valid bit per slot |
| acc_bank | input | 6 | Target bank per slot (0 = A, 1 = B) |
| busy | output | 1 | Schedule being played |
| cyc_idx | output | 3 | Index of the cycle being played |
| grant_a_vld | output | 1 | Bank A used this cycle |
| grant_a_slot | output | 3 | Slot owning bank A |
| grant_b_vld | output | 1 | Bank B used this cycle |
| grant_b_slot | output | 3 | Slot owning bank B |
| last_cyc | output | 1 | Final cycle of the schedule |
| stall_cnt | output | 3 | Cycles needed beyond one |
| rd_span | output | 3 | Cycles until all reads are done |

## Verification
The assertions take for granted that the captured access set stays constant for the whole of a schedule. They also assume that a new schedule is only ever started from the idle state, so the grant, stall and handshake properties relate outputs of a single capture.

The stimulus sweeps all 4096 combinations of valid and bank bits, one capture at a time, and waits for each schedule to finish before the next strobe. During every played cycle except the last, it holds `start` high and drives the inverted pattern, so the captured set must survive that noise. On the last cycle it drops `start` so that no unintended capture follows.

// File: rtl/dbs_pkg.sv
package dbs_pkg;
    typedef enum logic [0:0] {
        SQ_IDLE = 1'b0,
        SQ_PLAY = 1'b1
    } sq_state_e;
endpackage

// File: rtl/dbs_placer.sv
module dbs_placer #(
    parameter int unsigned N_PER_INSN = 3,
    localparam int unsigned S  = 2 * N_PER_INSN,
    localparam int unsigned PW = $clog2(S),
    localparam int unsigned CW = $clog2(S + 1)
) (
    input  logic [S-1:0]          acc_vld,
    input  logic [S-1:0]          acc_bank,
    output logic [S-1:0][PW-1:0]  slot_pos,
    output logic [CW-1:0]         n_cyc,
    output logic [CW-1:0]         rd_span
);
    // Earliest-free-cycle placement: count higher-priority hits on the same bank
    for (genvar i = 0; i < S; i++) begin : g_slot
        always_comb begin
            logic [PW-1:0] hits;
            hits = '0;
            for (int j = 0; j < i; j++) begin
                if (acc_vld[j] && (acc_bank[j] == acc_bank[i])) begin
                    hits = hits + PW'(1);
                end
            end
            slot_pos[i] = hits;
        end
    end

    logic [CW-1:0] cnt_a, cnt_b;

    always_comb begin
        cnt_a = '0;
        cnt_b = '0;
        for (int k = 0; k < S; k++) begin
            if (acc_vld[k]) begin
                if (acc_bank[k]) cnt_b = cnt_b + CW'(1);
                else             cnt_a = cnt_a + CW'(1);
            end
        end
        n_cyc = (cnt_a > cnt_b) ? cnt_a : cnt_b;
    end

    // Reads occupy the first N_PER_INSN slots
    always_comb begin
        rd_span = '0;
        for (int k = 0; k < N_PER_INSN; k++) begin
            if (acc_vld[k] && ((CW'(slot_pos[k]) + CW'(1)) > rd_span)) begin
                rd_span = CW'(slot_pos[k]) + CW'(1);
            end
        end
    end
endmodule

// File: rtl/dbs_sequencer.sv
module dbs_sequencer
    import dbs_pkg::*;
#(
    parameter int unsigned N_PER_INSN = 3,
    localparam int unsigned S  = 2 * N_PER_INSN,
    localparam int unsigned PW = $clog2(S),
    localparam int unsigned CW = $clog2(S + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [S-1:0]          acc_vld,
    input  logic [S-1:0]          acc_bank,
    input  logic [S-1:0][PW-1:0]  slot_pos,
    input  logic [CW-1:0]         n_cyc,
    input  logic [CW-1:0]         rd_span_in,
    output logic                  busy,
    output logic [CW-1:0]         cyc_idx,
    output logic                  grant_a_vld,
    output logic [PW-1:0]         grant_a_slot,
    output logic                  grant_b_vld,
    output logic [PW-1:0]         grant_b_slot,
    output logic                  last_cyc,
    output logic [CW-1:0]         stall_cnt,
    output logic [CW-1:0]         rd_span
);
    sq_state_e              state, state_nxt;
    logic [S-1:0]           cap_vld, cap_bank;
    logic [S-1:0][PW-1:0]   cap_pos;
    logic [CW-1:0]          cap_n;
    logic [CW-1:0]          idx;
    logic                   at_end;
    logic                   take;

    assign at_end = (idx == CW'(cap_n - CW'(1)));
    assign take   = (state == SQ_IDLE) && start;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= SQ_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            SQ_IDLE: if (start && (n_cyc != '0)) state_nxt = SQ_PLAY;  // capture
            SQ_PLAY: if (at_end)                 state_nxt = SQ_IDLE;  // finish
            default: state_nxt = SQ_IDLE;
        endcase
    end

    // Captured set and cycle counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_vld   <= '0;
            cap_bank  <= '0;
            cap_pos   <= '0;
            cap_n     <= '0;
            idx       <= '0;
            stall_cnt <= '0;
            rd_span   <= '0;
        end else if (take) begin
            cap_vld   <= acc_vld;
            cap_bank  <= acc_bank;
            cap_pos   <= slot_pos;
            cap_n     <= n_cyc;
            idx       <= '0;
            stall_cnt <= (n_cyc == '0) ? '0 : CW'(n_cyc - CW'(1));
            rd_span   <= rd_span_in;
        end else if (state == SQ_PLAY) begin
            idx <= at_end ? '0 : CW'(idx + CW'(1));
        end
    end

    // Output process
    always_comb begin
        busy         = (state == SQ_PLAY);
        cyc_idx      = busy ? idx : '0;
        last_cyc     = busy && at_end;
        grant_a_vld  = 1'b0;
        grant_a_slot = '0;
        grant_b_vld  = 1'b0;
        grant_b_slot = '0;
        if (busy) begin
            for (int k = 0; k < S; k++) begin
                if (cap_vld[k] && (CW'(cap_pos[k]) == idx)) begin
                    if (cap_bank[k]) begin
                        grant_b_vld  = 1'b1;
                        grant_b_slot = PW'(k);
                    end else begin
                        grant_a_vld  = 1'b1;
                        grant_a_slot = PW'(k);
                    end
                end
            end
        end
    end

    assert_distinct_owner_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_a_vld && grant_b_vld) |-> (grant_a_slot != grant_b_slot));
    assert_grant_only_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_a_vld || grant_b_vld) |-> busy);
    assert_last_in_play_R8: assert property (@(posedge clk) disable iff (!rst_n)
        last_cyc |-> busy);
    assert_end_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(last_cyc));
    assert_stall_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> ($stable(stall_cnt) && $stable(rd_span)));
endmodule

// File: rtl/dbs_sched.sv
module dbs_sched #(
    parameter int unsigned N_PER_INSN = 3,
    localparam int unsigned S  = 2 * N_PER_INSN,
    localparam int unsigned PW = $clog2(S),
    localparam int unsigned CW = $clog2(S + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [S-1:0]  acc_vld,
    input  logic [S-1:0]  acc_bank,
    output logic          busy,
    output logic [CW-1:0] cyc_idx,
    output logic          grant_a_vld,
    output logic [PW-1:0] grant_a_slot,
    output logic          grant_b_vld,
    output logic [PW-1:0] grant_b_slot,
    output logic          last_cyc,
    output logic [CW-1:0] stall_cnt,
    output logic [CW-1:0] rd_span
);
    logic [S-1:0][PW-1:0] slot_pos;
    logic [CW-1:0]        n_cyc;
    logic [CW-1:0]        span_c;

    dbs_placer #(.N_PER_INSN(N_PER_INSN)) u_placer (
        .acc_vld  (acc_vld),
        .acc_bank (acc_bank),
        .slot_pos (slot_pos),
        .n_cyc    (n_cyc),
        .rd_span  (span_c)
    );

    dbs_sequencer #(.N_PER_INSN(N_PER_INSN)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .acc_vld      (acc_vld),
        .acc_bank     (acc_bank),
        .slot_pos     (slot_pos),
        .n_cyc        (n_cyc),
        .rd_span_in   (span_c),
        .busy         (busy),
        .cyc_idx      (cyc_idx),
        .grant_a_vld  (grant_a_vld),
        .grant_a_slot (grant_a_slot),
        .grant_b_vld  (grant_b_vld),
        .grant_b_slot (grant_b_slot),
        .last_cyc     (last_cyc),
        .stall_cnt    (stall_cnt),
        .rd_span      (rd_span)
    );
endmodule

// File: tb/dbs_sched_tb.sv
module dbs_sched_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [5:0] acc_vld = '0;
    logic [5:0] acc_bank = '0;
    logic       busy, grant_a_vld, grant_b_vld, last_cyc;
    logic [2:0] cyc_idx, grant_a_slot, grant_b_slot, stall_cnt, rd_span;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    dbs_sched u_dut (
        .clk(clk), .rst_n(rst_n), .start(start),
        .acc_vld(acc_vld), .acc_bank(acc_bank),
        .busy(busy), .cyc_idx(cyc_idx),
        .grant_a_vld(grant_a_vld), .grant_a_slot(grant_a_slot),
        .grant_b_vld(grant_b_vld), .grant_b_slot(grant_b_slot),
        .last_cyc(last_cyc), .stall_cnt(stall_cnt), .rd_span(rd_span)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        finish_run();
    end

    initial begin
        int pos [6];
        int ca, cb, n, span, ea, eb;
        bit seen_wr_a, seen_wr_b, r5_ok;
        repeat (3) @(negedge clk);
        // R10: reset values
        chk(!busy && !grant_a_vld && !grant_b_vld && !last_cyc, "R10 ctl", busy, 0);
        chk(stall_cnt == 0 && rd_span == 0, "R10 regs", stall_cnt, 0);
        rst_n = 1'b1;

        for (int v = 0; v < 64; v++) begin
            for (int b = 0; b < 64; b++) begin
                // Expected placement per R1/R3/R4
                ca = 0; cb = 0; span = 0;
                for (int i = 0; i < 6; i++) begin
                    pos[i] = 0;
                    for (int j = 0; j < i; j++)
                        if (v[j] && (b[j] == b[i])) pos[i]++;
                    if (v[i]) begin
                        if (b[i]) cb++; else ca++;
                        if (i < 3 && pos[i] + 1 > span) span = pos[i] + 1;
                    end
                end
                n = (ca > cb) ? ca : cb;

                @(negedge clk);
                chk(!busy, "R8 idle before capture", busy, 0);
                acc_vld = 6'(v); acc_bank = 6'(b); start = 1'b1;
                @(negedge clk);
                chk(int'(stall_cnt) == ((n > 0) ? n - 1 : 0), "R6 stall", stall_cnt, (n > 0) ? n - 1 : 0);
                chk(int'(rd_span) == span, "R7 span", rd_span, span);
                seen_wr_a = 0; seen_wr_b = 0; r5_ok = 1;
                if (n == 0) begin
                    chk(!busy && !grant_a_vld && !grant_b_vld, "R8 empty stays idle", busy, 0);
                    start = 1'b0;
                end
                for (int k = 0; k < n; k++) begin
                    if (k > 0) @(negedge clk);
                    ea = -1; eb = -1;
                    for (int i = 0; i < 6; i++)
                        if (v[i] && pos[i] == k) begin
                            if (b[i]) eb = i; else ea = i;
                        end
                    chk(busy && int'(cyc_idx) == k, "R8 cycle index", cyc_idx, k);
                    chk(last_cyc == (k == n - 1), "R8 last", last_cyc, k == n - 1);
                    chk((ea < 0) ? !grant_a_vld : (grant_a_vld && int'(grant_a_slot) == ea),
                        "R3 bank A owner", grant_a_vld ? int'(grant_a_slot) : -1, ea);
                    chk((eb < 0) ? !grant_b_vld : (grant_b_vld && int'(grant_b_slot) == eb),
                        "R2 R4 R9 bank B owner", grant_b_vld ? int'(grant_b_slot) : -1, eb);
                    if (grant_a_vld) begin
                        if (grant_a_slot >= 3) seen_wr_a = 1;
                        else if (seen_wr_a) r5_ok = 0;
                    end
                    if (grant_b_vld) begin
                        if (grant_b_slot >= 3) seen_wr_b = 1;
                        else if (seen_wr_b) r5_ok = 0;
                    end
                    if (k < n - 1) begin
                        start = 1'b1; acc_vld = ~6'(v); acc_bank = ~6'(b);  // R9 noise
                    end else begin
                        start = 1'b0;
                    end
                end
                chk(r5_ok, "R5 reads first", r5_ok, 1);
            end
        end
        @(negedge clk);
        chk(!busy, "R8 final idle", busy, 0);
        finish_run();
    end
endmodule